// File: doc/BRIEF.md
# Triangular Dither PWM Sequencer with Extended-Resolution Averager

This block drives one PWM pin whose carrier period is locked to one ADC conversion period. The duty cycle is reloaded at the start of every carrier period and follows a triangle. An external RC network smooths the PWM into a small triangular dither, and an external inverting summing stage adds that dither to the signal the ADC sees. One triangle spans exactly OSR conversions, with OSR = 2 * 2^EXTRA_BITS. Each conversion lines up with one triangle step through a trigger pulse at the start of every carrier period.

The same block averages the conversions of a burst. The summing stage inverts around a fixed offset, so the block forms the offset minus the halved sum of the OSR samples. This word carries EXTRA_BITS more bits than the ADC. It encodes how often the upper of two adjacent codes showed up across the burst. A single-cycle tick starts a burst. A tick that arrives while a burst is running restarts both the triangle and the sum.

Top module: `dither_pwm_seq`

## Requirements
- R1: While reset is held and afterwards until the first start tick, `pwm_o`, `conv_trig_o` and `result_valid_o` are low.
- R2: The clock edge that samples `burst_start_i` high begins a burst, and `conv_trig_o` is high in the following cycle. The trigger then repeats once every CONV_CLKS cycles, for exactly OSR pulses in total. After that, trigger and PWM stay low until the next start tick.
- R3: In carrier period k of a burst (k = 0 .. OSR-1), `pwm_o` is high for the first D(k) cycles of the period and low for the rest. With H = OSR/2, D(k) = DUTY_LO + k*DUTY_STEP for k < H and D(k) = DUTY_LO + (OSR-1-k)*DUTY_STEP for k >= H. For the defaults (CONV_CLKS 56, OSR 16) this gives 0, 7, ..., 49, 49, ..., 7, 0.
- R4: A start tick during a running burst restarts the sequence. A trigger follows at once, and the next OSR periods repeat the R3 pattern from k = 0.
- R5: After a start tick, the block adds the next OSR samples that `adc_valid_i` marks. In the cycle after the edge that takes the OSR-th sample, `result_valid_o` is high for exactly one cycle, and `result_o` equals (OFFSET - floor(sum/2)) mod 2^(ADC_W+EXTRA_BITS). OSR = 2 * 2^EXTRA_BITS, so the defaults give OSR 16 and a 15-bit result.
- R6: Samples that arrive before any start tick, or after the OSR-th sample of a burst, leave `result_valid_o` low and leave `result_o` unchanged.
- R7: A sample presented on the same edge as a start tick is discarded. The count begins with the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start_i | input | 1 | Single-cycle tick that starts or restarts a burst |
| adc_valid_i | input | 1 | Marks a conversion result on `adc_data_i` |
| adc_data_i | input | ADC_W | Raw ADC conversion code |
| pwm_o | output | 1 | Dither PWM, carrier period CONV_CLKS cycles |
| conv_trig_o | output | 1 | One-cycle conversion trigger at each carrier period start |
| result_o | output | ADC_W+EXTRA_BITS | Offset-corrected, extended-resolution estimate |
| result_valid_o | output | 1 | One-cycle strobe when `result_o` updates |

## Verification
The bench walks a whole burst cycle by cycle. A design that mis-indexes the table or breaks the fold at the triangle midpoint would show a duty error at one step. One that counts the carrier wrong would move a trigger. One that fails to stop after OSR periods would produce a seventeenth trigger. Several sample sets stress the halving and the offset subtraction at both ends of the code range, which would expose a dropped carry or a shift by the wrong amount. The directed cases cover four situations: a restart mid-burst (a stale step index would show), a sample that arrives on the start edge (the result would come one sample early), samples before any start tick, and samples after a result (a spurious strobe or a changed result would show).

// File: rtl/dither_pkg.sv
package dither_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Duty level of triangle step k: linear rise over the first half, mirrored fall over the second.
    function automatic int unsigned tri_level(input int unsigned k, input int unsigned osr,
                                              input int unsigned lo, input int unsigned stp);
        int unsigned half;
        half = osr / 2;
        if (k < half) return lo + k * stp;
        return lo + (osr - 1 - k) * stp;
    endfunction

endpackage

// File: rtl/dither_step_seq.sv
module dither_step_seq
    import dither_pkg::*;
#(
    parameter int unsigned CONV_CLKS = 56,
    parameter int unsigned OSR       = 16,
    localparam int unsigned CNT_W    = $clog2(CONV_CLKS),
    localparam int unsigned STEP_W   = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              run_o,
    output logic              trig_o,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(CONV_CLKS - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(OSR - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [STEP_W-1:0]  step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start_i) begin
            seq_d.ph   = PH_RUN;
            seq_d.cnt  = '0;
            seq_d.step = '0;
        end else if (seq_q.ph == PH_RUN) begin
            if (seq_q.cnt == CNT_LAST) begin
                seq_d.cnt = '0;
                if (seq_q.step == STEP_LAST) begin
                    seq_d.ph = PH_IDLE;
                end else begin
                    seq_d.step = seq_q.step + 1'b1;
                end
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_o  = (seq_q.ph == PH_RUN);
    assign trig_o = run_o && (seq_q.cnt == '0);
    assign step_o = seq_q.step;
    assign cnt_o  = seq_q.cnt;

    // R2: a start tick is followed at once by a trigger
    assert_start_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> trig_o);

    // R2: a trigger never lasts more than one cycle
    assert_trig_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o && !start_i |=> !trig_o);

    // R2: an idle sequencer without a start tick stays silent
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o && !start_i |=> !trig_o);

endmodule

// File: rtl/dither_pwm_cmp.sv
module dither_pwm_cmp
    import dither_pkg::*;
#(
    parameter int unsigned CONV_CLKS = 56,
    parameter int unsigned OSR       = 16,
    parameter int unsigned DUTY_LO   = 0,
    parameter int unsigned DUTY_STEP = 7,
    localparam int unsigned CNT_W    = $clog2(CONV_CLKS),
    localparam int unsigned STEP_W   = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              pwm_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CLKS - 1);

    logic [CNT_W:0] duty_tab [OSR];

    for (genvar g = 0; g < OSR; g++) begin : g_tab
        assign duty_tab[g] = (CNT_W+1)'(tri_level(g, OSR, DUTY_LO, DUTY_STEP));
    end

    assign pwm_o = run_i && ({1'b0, cnt_i} < duty_tab[step_i]);

    // R3: every carrier period ends low, so each step yields a distinct pulse
    assert_period_ends_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && (cnt_i == CNT_LAST) |-> !pwm_o);

endmodule

// File: rtl/dither_accum.sv
module dither_accum #(
    parameter int unsigned ADC_W  = 12,
    parameter int unsigned OSR    = 16,
    parameter int unsigned OFFSET = 32767,
    localparam int unsigned N_W   = $clog2(OSR),
    localparam int unsigned SUM_W = ADC_W + N_W,
    localparam int unsigned OUT_W = SUM_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             smp_valid_i,
    input  logic [ADC_W-1:0] smp_i,
    output logic [OUT_W-1:0] res_o,
    output logic             res_valid_o
);

    localparam logic [N_W-1:0]   N_LAST  = N_W'(OSR - 1);
    localparam logic [OUT_W-1:0] OFS_VAL = OUT_W'(OFFSET);

    typedef struct packed {
        logic              on;
        logic [N_W-1:0]    n;
        logic [SUM_W-1:0]  sum;
        logic [OUT_W-1:0]  res;
        logic              vld;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [SUM_W-1:0] sum_next;

    always_comb begin
        acc_d     = acc_q;
        acc_d.vld = 1'b0;
        sum_next  = acc_q.sum + SUM_W'(smp_i);
        if (start_i) begin
            acc_d.on  = 1'b1;
            acc_d.n   = '0;
            acc_d.sum = '0;
        end else if (acc_q.on && smp_valid_i) begin
            acc_d.sum = sum_next;
            acc_d.n   = acc_q.n + 1'b1;
            if (acc_q.n == N_LAST) begin
                acc_d.on  = 1'b0;
                acc_d.vld = 1'b1;
                acc_d.res = OFS_VAL - sum_next[SUM_W-1:1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign res_o       = acc_q.res;
    assign res_valid_o = acc_q.vld;

    // R5: the result strobe lasts a single cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R6: with no burst open, samples neither strobe nor change the result
    assert_idle_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q.on && !start_i |=> !res_valid_o && $stable(res_o));

endmodule

// File: rtl/dither_pwm_seq.sv
module dither_pwm_seq #(
    parameter int unsigned CONV_CLKS  = 56,
    parameter int unsigned EXTRA_BITS = 3,
    parameter int unsigned ADC_W      = 12,
    parameter int unsigned DUTY_LO    = 0,
    parameter int unsigned DUTY_STEP  = 7,
    parameter int unsigned OFFSET     = (1 << (ADC_W + EXTRA_BITS)) - 1,
    localparam int unsigned OSR       = 2 << EXTRA_BITS,
    localparam int unsigned OUT_W     = ADC_W + EXTRA_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start_i,
    input  logic             adc_valid_i,
    input  logic [ADC_W-1:0] adc_data_i,
    output logic             pwm_o,
    output logic             conv_trig_o,
    output logic [OUT_W-1:0] result_o,
    output logic             result_valid_o
);

    localparam int unsigned CNT_W  = $clog2(CONV_CLKS);
    localparam int unsigned STEP_W = $clog2(OSR);

    logic              run;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  cnt;

    dither_step_seq #(
        .CONV_CLKS (CONV_CLKS),
        .OSR       (OSR)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (burst_start_i),
        .run_o   (run),
        .trig_o  (conv_trig_o),
        .step_o  (step),
        .cnt_o   (cnt)
    );

    dither_pwm_cmp #(
        .CONV_CLKS (CONV_CLKS),
        .OSR       (OSR),
        .DUTY_LO   (DUTY_LO),
        .DUTY_STEP (DUTY_STEP)
    ) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .step_i (step),
        .cnt_i  (cnt),
        .pwm_o  (pwm_o)
    );

    dither_accum #(
        .ADC_W  (ADC_W),
        .OSR    (OSR),
        .OFFSET (OFFSET)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (burst_start_i),
        .smp_valid_i (adc_valid_i),
        .smp_i       (adc_data_i),
        .res_o       (result_o),
        .res_valid_o (result_valid_o)
    );

endmodule

// File: tb/sim_dither_pwm_seq.sv
`timescale 1ns/1ps
module sim_dither_pwm_seq;

    localparam int CONV = 56;
    localparam int OSR  = 16;
    localparam int OW   = 15;
    localparam int OFS  = 32767;
    localparam int NV   = 5;
    // each vector: {base code[11:0], count of upper codes[4:0]}
    localparam logic [16:0] VEC [NV] = '{
        {12'd0,    5'd0},
        {12'd100,  5'd6},
        {12'd4095, 5'd0},
        {12'd2047, 5'd15},
        {12'd1000, 5'd8}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, av = 1'b0;
    logic [11:0] ad = '0;
    logic pwm, trig, rv;
    logic [OW-1:0] res;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dither_pwm_seq u0 (
        .clk(clk), .rst_n(rst_n), .burst_start_i(start), .adc_valid_i(av),
        .adc_data_i(ad), .pwm_o(pwm), .conv_trig_o(trig), .result_o(res),
        .result_valid_o(rv)
    );

    function automatic int duty(input int k);
        return (k < OSR/2) ? 7*k : 7*(OSR-1-k);
    endfunction

    function automatic int expect_res(input int base, input int ups);
        int s;
        s = OSR*base + ups;
        return (OFS - (s >> 1)) & ((1 << OW) - 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // called at the negedge where count=0 of step 0; ends one negedge past the burst
    task automatic check_burst(input string tag);
        int bad_p, bad_t;
        for (int k = 0; k < OSR; k++) begin
            bad_p = 0; bad_t = 0;
            for (int c = 0; c < CONV; c++) begin
                if (pwm !== (c < duty(k))) bad_p++;
                if (trig !== (c == 0)) bad_t++;
                @(negedge clk);
            end
            chk({"R3 duty ", tag}, bad_p, 0);
            chk({"R2 trigger ", tag}, bad_t, 0);
        end
        chk({"R2 idle trig ", tag}, int'(trig), 0);
        chk({"R2 idle pwm ", tag}, int'(pwm), 0);
        @(negedge clk);
        chk({"R2 still idle ", tag}, int'(trig | pwm), 0);
    endtask

    // feeds OSR samples starting on the next negedge, then checks the strobe
    task automatic feed(input int base, input int ups, input string tag);
        for (int k = 0; k < OSR; k++) begin
            @(negedge clk) av = 1'b1; ad = 12'(base + ((k < ups) ? 1 : 0));
        end
        @(negedge clk) av = 1'b0;
        chk({"R5 strobe ", tag}, int'(rv), 1);
        chk({"R5 value ", tag}, int'(res), expect_res(base, ups));
        @(negedge clk);
        chk({"R5 strobe one cycle ", tag}, int'(rv), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [OW-1:0] held;
        repeat (3) @(negedge clk);
        chk("R1 pwm in reset", int'(pwm), 0);
        chk("R1 trig in reset", int'(trig), 0);
        chk("R1 valid in reset", int'(rv), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(pwm | trig | rv), 0);

        // R6: samples before any start tick are ignored
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) av = 1'b1; ad = 12'd77;
            if (rv) chk("R6 pre-start strobe", 1, 0);
        end
        @(negedge clk) av = 1'b0;
        chk("R6 pre-start strobe", int'(rv), 0);
        chk("R6 pre-start result", int'(res), 0);

        // vector table: R5
        for (int v = 0; v < NV; v++) begin
            pulse_start();
            feed(int'(VEC[v][16:5]), int'(VEC[v][4:0]), $sformatf("vec%0d", v));
        end

        // R6: extra samples after a result change nothing
        held = res;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) av = 1'b1; ad = 12'd3000;
        end
        @(negedge clk) av = 1'b0;
        chk("R6 post-burst strobe", int'(rv), 0);
        chk("R6 post-burst result", int'(res), int'(held));

        // R7: sample on the start edge is discarded
        @(negedge clk) start = 1'b1; av = 1'b1; ad = 12'd4000;
        for (int k = 0; k < OSR; k++) begin
            @(negedge clk) start = 1'b0; av = 1'b1; ad = 12'd10;
            if (k == OSR-1) chk("R7 no early strobe", int'(rv), 0);
        end
        @(negedge clk) av = 1'b0;
        chk("R7 strobe", int'(rv), 1);
        chk("R7 value", int'(res), expect_res(10, 0));

        // R2/R3: full burst waveform
        pulse_start();
        check_burst("burst");

        // R4: restart in the middle of a burst
        pulse_start();
        repeat (3*CONV + 10) @(negedge clk);
        pulse_start();
        chk("R4 restart trigger", int'(trig), 1);
        check_burst("restart");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule